// File: doc/BRIEF.md
# ADC Output Word Formatter

This block takes each 14-bit offset-binary sample from an analog-to-digital converter core, together with its valid strobe, and turns it into the word the serializer sends out. Four control inputs come from the configuration register block: two's-complement enable, randomizer enable, test-pattern enable, and a 14-bit test pattern. The pattern arrives in two pieces. A 6-bit upper field fills the top of the word and an 8-bit lower field fills the rest.

A mode decoder reduces the three enables to one named mode per sample. The modes are PASS, TWOS, SCRAM, TWOS_SCRAM and PATTERN. PATTERN wins whenever its enable is set. A combinational transform builds the word for the chosen mode. An output register captures it on the edge where the strobe is high, so every formatted word appears exactly one clock after its sample. On cycles without a strobe the register holds its previous word.

Top module: `adc_word_formatter`

## Requirements
- R1: While reset is asserted, and directly after it is released, `fmt_word` is 0 and `fmt_valid` is 0.
- R2: With all three enables low (mode PASS), `fmt_word` equals the offset-binary `smp_raw` captured at the previous clock edge where `smp_valid` was high.
- R3: With only two's complement enabled (mode TWOS), the output is the sample with bit 13 inverted and bits 12..0 unchanged.
- R4: With only the randomizer enabled (mode SCRAM), output bit 0 equals sample bit 0, and each output bit k for k = 1..13 equals sample bit k XOR sample bit 0.
- R5: With both transforms enabled (mode TWOS_SCRAM), bit 13 is inverted first, and the randomizer of R4 is then applied to that result.
- R6: When the test-pattern enable is high (mode PATTERN), the output is `{pat_hi, pat_lo}`, with `pat_hi` in bits 13..8 and `pat_lo` in bits 7..0. This holds whatever the two's-complement and randomizer enables are set to.
- R7: `fmt_valid` equals `smp_valid` delayed by one clock.
- R8: On a clock edge where `smp_valid` is low, `fmt_word` keeps its value, whatever changes occur on `smp_raw`, the enables or the pattern fields.
- R9: The enables and pattern fields take effect only at the edge that captures a sample. A mode change therefore alters the output starting with the next strobed sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | Strobe marking a new raw sample |
| smp_raw | input | 14 | Raw offset-binary sample |
| ctl_twos | input | 1 | Enables two's-complement output |
| ctl_rand | input | 1 | Enables the randomizer |
| ctl_pat_en | input | 1 | Enables test-pattern substitution |
| pat_hi | input | 6 | Upper field of the test pattern (bits 13..8) |
| pat_lo | input | 8 | Lower field of the test pattern (bits 7..0) |
| fmt_word | output | 14 | Formatted output word |
| fmt_valid | output | 1 | Strobe marking a new formatted word |

## Verification
Two's complement and the randomizer can act on the same sample. The bench provokes this by setting both enables for both directed and random samples, and judges the result against a model that inverts bit 13 before it randomizes. The test-pattern enable can also be raised on the same cycle that the other two enables are high. Those cycles are judged by requiring the exact `{pat_hi, pat_lo}` word, so any leak of either transform into PATTERN mode shows up as a mismatch.

// File: rtl/awf_pkg.sv
package awf_pkg;

    typedef enum logic [2:0] {
        FM_PASS       = 3'd0,
        FM_TWOS       = 3'd1,
        FM_SCRAM      = 3'd2,
        FM_TWOS_SCRAM = 3'd3,
        FM_PATTERN    = 3'd4
    } fmt_mode_e;

endpackage

// File: rtl/awf_mode_sel.sv
module awf_mode_sel
    import awf_pkg::*;
(
    input  logic      twos_en,
    input  logic      rand_en,
    input  logic      pat_en,
    output fmt_mode_e mode
);

    // The pattern enable outranks both transforms.
    always_comb begin
        if (pat_en) begin
            mode = FM_PATTERN;
        end else begin
            unique case ({twos_en, rand_en})
                2'b00:   mode = FM_PASS;
                2'b10:   mode = FM_TWOS;
                2'b01:   mode = FM_SCRAM;
                default: mode = FM_TWOS_SCRAM;
            endcase
        end
    end

endmodule

// File: rtl/awf_xform.sv
module awf_xform
    import awf_pkg::*;
#(
    parameter int DATA_W = 14
) (
    input  fmt_mode_e          mode,
    input  logic [DATA_W-1:0]  raw,
    input  logic [DATA_W-1:0]  pattern,
    output logic [DATA_W-1:0]  word
);

    localparam int MSB = DATA_W - 1;

    // Offset binary to two's complement: flip the sign position.
    function automatic logic [DATA_W-1:0] flip_msb(input logic [DATA_W-1:0] d);
        logic [DATA_W-1:0] r;
        r      = d;
        r[MSB] = ~d[MSB];
        return r;
    endfunction

    // Every bit above the LSB is XORed with the LSB.
    function automatic logic [DATA_W-1:0] scramble(input logic [DATA_W-1:0] d);
        logic [DATA_W-1:0] r;
        r = d;
        for (int k = 1; k < DATA_W; k++) begin
            r[k] = d[k] ^ d[0];
        end
        return r;
    endfunction

    always_comb begin
        unique case (mode)
            FM_PASS:       word = raw;
            FM_TWOS:       word = flip_msb(raw);
            FM_SCRAM:      word = scramble(raw);
            FM_TWOS_SCRAM: word = scramble(flip_msb(raw));
            FM_PATTERN:    word = pattern;
            default:       word = raw;
        endcase
    end

endmodule

// File: rtl/awf_out_reg.sv
module awf_out_reg #(
    parameter int DATA_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q,
    output logic              q_valid
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q_valid <= 1'b0;
        end else begin
            q_valid <= load;
            if (load) begin
                q <= d;
            end
        end
    end

endmodule

// File: rtl/adc_word_formatter.sv
module adc_word_formatter
    import awf_pkg::*;
#(
    parameter int DATA_W   = 14,
    parameter int PAT_HI_W = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       smp_valid,
    input  logic [DATA_W-1:0]          smp_raw,
    input  logic                       ctl_twos,
    input  logic                       ctl_rand,
    input  logic                       ctl_pat_en,
    input  logic [PAT_HI_W-1:0]        pat_hi,
    input  logic [DATA_W-PAT_HI_W-1:0] pat_lo,
    output logic [DATA_W-1:0]          fmt_word,
    output logic                       fmt_valid
);

    localparam int PAT_LO_W = DATA_W - PAT_HI_W;

    fmt_mode_e         cur_mode;
    logic [DATA_W-1:0] pat_word;
    logic [DATA_W-1:0] next_word;

    assign pat_word = {pat_hi, pat_lo[PAT_LO_W-1:0]};

    awf_mode_sel u_mode (
        .twos_en (ctl_twos),
        .rand_en (ctl_rand),
        .pat_en  (ctl_pat_en),
        .mode    (cur_mode)
    );

    awf_xform #(.DATA_W(DATA_W)) u_xform (
        .mode    (cur_mode),
        .raw     (smp_raw),
        .pattern (pat_word),
        .word    (next_word)
    );

    awf_out_reg #(.DATA_W(DATA_W)) u_oreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (smp_valid),
        .d       (next_word),
        .q       (fmt_word),
        .q_valid (fmt_valid)
    );

endmodule

// File: rtl/awf_checker.sv
module awf_checker #(
    parameter int DATA_W   = 14,
    parameter int PAT_HI_W = 6
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       smp_valid,
    input logic [DATA_W-1:0]          smp_raw,
    input logic                       ctl_twos,
    input logic                       ctl_rand,
    input logic                       ctl_pat_en,
    input logic [PAT_HI_W-1:0]        pat_hi,
    input logic [DATA_W-PAT_HI_W-1:0] pat_lo,
    input logic [DATA_W-1:0]          fmt_word,
    input logic                       fmt_valid
);

    assert_valid_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_valid == $past(smp_valid));

    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(fmt_word));

    assert_pattern_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && ctl_pat_en) |=> fmt_word == $past({pat_hi, pat_lo}));

    assert_pass_through_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !ctl_pat_en && !ctl_twos && !ctl_rand) |=> fmt_word == $past(smp_raw));

    assert_twos_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !ctl_pat_en && ctl_twos && !ctl_rand)
        |=> (fmt_word[DATA_W-1] != $past(smp_raw[DATA_W-1]))
            && (fmt_word[DATA_W-2:0] == $past(smp_raw[DATA_W-2:0])));

    assert_scram_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !ctl_pat_en && !ctl_twos && ctl_rand)
        |=> (fmt_word[0] == $past(smp_raw[0]))
            && (fmt_word[DATA_W-1:1] ==
                ($past(smp_raw[DATA_W-1:1]) ^ {(DATA_W-1){$past(smp_raw[0])}})));

endmodule

bind adc_word_formatter awf_checker #(.DATA_W(DATA_W), .PAT_HI_W(PAT_HI_W)) u_chk (.*);

// File: tb/adc_word_formatter_bench.sv
`timescale 1ns/1ps
module adc_word_formatter_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [13:0] smp_raw = '0;
    logic        ctl_twos = 1'b0;
    logic        ctl_rand = 1'b0;
    logic        ctl_pat_en = 1'b0;
    logic [5:0]  pat_hi = '0;
    logic [7:0]  pat_lo = '0;
    logic [13:0] fmt_word;
    logic        fmt_valid;

    int          checks = 0;
    int          errors = 0;
    logic [13:0] exp_word = '0;
    int unsigned seed_dummy;

    always #10 clk = ~clk;

    adc_word_formatter u_adc_word_formatter (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_raw(smp_raw),
        .ctl_twos(ctl_twos), .ctl_rand(ctl_rand), .ctl_pat_en(ctl_pat_en),
        .pat_hi(pat_hi), .pat_lo(pat_lo), .fmt_word(fmt_word), .fmt_valid(fmt_valid)
    );

    function automatic logic [13:0] model(input logic [13:0] raw, input logic tw,
                                          input logic rd, input logic pe,
                                          input logic [5:0] hi, input logic [7:0] lo);
        logic [13:0] w;
        if (pe) return {hi, lo};
        w = raw;
        if (tw) w[13] = ~w[13];
        if (rd) for (int k = 1; k < 14; k++) w[k] = w[k] ^ w[0];
        return w;
    endfunction

    task automatic check(input string req, input logic [13:0] act_w, input logic [13:0] exp_w,
                         input logic act_v, input logic exp_v);
        checks++;
        if (act_w !== exp_w || act_v !== exp_v) begin
            errors++;
            $display("FAIL %s word=%h valid=%b expected word=%h valid=%b",
                     req, act_w, act_v, exp_w, exp_v);
        end
    endtask

    // Drive one cycle of stimulus at a falling edge; check at the next falling edge.
    task automatic step(input string req, input logic v, input logic [13:0] raw,
                        input logic tw, input logic rd, input logic pe,
                        input logic [5:0] hi, input logic [7:0] lo);
        @(negedge clk);
        smp_valid = v; smp_raw = raw; ctl_twos = tw; ctl_rand = rd;
        ctl_pat_en = pe; pat_hi = hi; pat_lo = lo;
        if (v) exp_word = model(raw, tw, rd, pe, hi, lo);
        @(negedge clk);
        check(req, fmt_word, exp_word, fmt_valid, v);
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        seed_dummy = $urandom(32'h5EED_0A7C);
        repeat (3) @(negedge clk);
        check("R1", fmt_word, 14'h0000, fmt_valid, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", fmt_word, 14'h0000, fmt_valid, 1'b0);

        // Directed corners
        step("R2", 1, 14'h0000, 0, 0, 0, 6'h00, 8'h00);
        step("R2", 1, 14'h1ABC, 0, 0, 0, 6'h3F, 8'hFF);
        step("R3", 1, 14'h2000, 1, 0, 0, 6'h00, 8'h00);
        step("R3", 1, 14'h1FFF, 1, 0, 0, 6'h00, 8'h00);
        step("R4", 1, 14'h3FFF, 0, 1, 0, 6'h00, 8'h00);
        step("R4", 1, 14'h2AAA, 0, 1, 0, 6'h00, 8'h00);
        step("R5", 1, 14'h0001, 1, 1, 0, 6'h00, 8'h00);
        step("R5", 1, 14'h3FFE, 1, 1, 0, 6'h00, 8'h00);
        step("R6", 1, 14'h1234, 1, 1, 1, 6'h2D, 8'h5A);
        step("R6", 1, 14'h3FFF, 0, 0, 1, 6'h01, 8'h80);
        // Idle cycles: everything changes, output must hold (R8), valid drops (R7)
        step("R8", 0, 14'h0F0F, 0, 1, 0, 6'h15, 8'hAA);
        step("R7", 0, 14'h3333, 1, 0, 1, 6'h3F, 8'h00);
        // Mode change takes effect only at the next strobed sample (R9)
        step("R9", 1, 14'h0155, 1, 0, 0, 6'h00, 8'h00);
        step("R9", 0, 14'h0155, 0, 1, 1, 6'h11, 8'h22);
        step("R9", 1, 14'h0155, 0, 1, 0, 6'h11, 8'h22);

        // Constrained random: enables mixed, pattern biased low, valid mostly high
        for (int n = 0; n < 400; n++) begin
            logic v, tw, rd, pe;
            v  = ($urandom_range(0, 3) != 0);
            tw = $urandom_range(0, 1);
            rd = $urandom_range(0, 1);
            pe = ($urandom_range(0, 4) == 0);
            step(pe ? "R6" : (tw && rd) ? "R5" : rd ? "R4" : tw ? "R3" : v ? "R2" : "R8",
                 v, 14'($urandom), tw, rd, pe, 6'($urandom), 8'($urandom));
        end

        // Reset in mid-stream clears the output again
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", fmt_word, 14'h0000, fmt_valid, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule